// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler

This block turns a fast system clock into the edge timing of an SPI master's serial clock. Software writes a 16-bit clock-select word that holds two fields: a prescale count and a coded divide ratio. The block multiplies the two to get the number of system cycles between serial-clock edges. It then emits a one-cycle tick for each edge, which is twice per bit. It also emits a level that follows the serial clock, starting from its idle value.

The counters run only while the run input is high. Dropping the run input clears both counters and the level. The first edge after the run input rises therefore comes one full period later. The shift logic and the pin drivers use the tick and the level. Neither of them is part of this block.

A clock-select write that lands while the clock is running does not disturb the period already in progress. It is held in a pending copy and becomes active when the counters wrap. This means the serial clock never gets a shortened half-period.

Top module: `spi_sck_prescaler`

## Requirements
- R1: After a synchronous reset `edge_tick` and `sck_phase` are 0, and the active setting is a prescale of 1 with divide code 0, which gives 2 cycles per edge.
- R2: The prescale value is bits 12:8 of the written word plus one, giving 1 to 32. Bits 15:13 and 7:3 have no effect on timing.
- R3: Divide code (bits 2:0) values 0, 1, 2, 3 and 4 select divide ratios of 2, 4, 8, 16 and 32. The number of cycles between ticks is the prescale value times that ratio.
- R4: Divide code 7 selects a ratio of 1. With prescale field 0 and code 7, a tick appears on every cycle while running.
- R5: Divide codes 5 and 6 behave as a ratio of 2.
- R6: While `sck_run` is low, no tick is produced and `sck_phase` is 0 one cycle later.
- R7: Let clock edge 1 be the first edge that samples `sck_run` high after it was low. With N cycles per edge, the first tick is visible after edge N. Later ticks follow every N cycles.
- R8: A write sampled in the middle of a running period leaves the current period at its old length. The new setting governs the periods that follow.
- R9: A write sampled in the same cycle as the counters wrap governs the very next period.
- R10: `sck_phase` inverts in the cycle that `edge_tick` is high and holds otherwise, except for the clear of R6.
- R11: Raising `rst` in the middle of a run returns the outputs and the setting to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csr_we | input | 1 | Clock-select write strobe |
| csr_wdata | input | 16 | Clock-select word: prescale-1 in 12:8, divide code in 2:0 |
| sck_run | input | 1 | Serial clock run enable |
| edge_tick | output | 1 | One-cycle pulse per serial-clock edge |
| sck_phase | output | 1 | Serial-clock level, 0 when idle |

## Verification
A clock-select write and a counter wrap can fall in the same cycle. In that case the write must bypass the pending copy and become the active setting at once. The bench provokes this by placing the write strobe in the last cycle of a period, timed from the previous tick. A mid-period write is also tried as a contrast. Each case is judged by measuring the next two tick intervals against the old and new ratios, which the bench computes.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

  localparam int CSR_W    = 16;
  localparam int PRE_W    = 5;
  localparam int PRE_LSB  = 8;
  localparam int CODE_W   = 3;
  localparam int CODE_LSB = 0;
  localparam int DIV_W    = 5;

  typedef struct packed {
    logic [PRE_W-1:0] pre_max;
    logic [DIV_W-1:0] div_max;
  } clk_cfg_t;

  // terminal count of the coded stage: ratio minus one
  function automatic logic [DIV_W-1:0] code_to_max(input logic [CODE_W-1:0] code);
    int ratio;
    case (code)
      3'd7:                      ratio = 1;
      3'd0, 3'd1, 3'd2, 3'd3, 3'd4: ratio = 2 << int'(code);
      default:                   ratio = 2;
    endcase
    return DIV_W'(ratio - 1);
  endfunction

  function automatic clk_cfg_t decode_csr(input logic [CSR_W-1:0] w);
    clk_cfg_t c;
    c.pre_max = w[PRE_LSB +: PRE_W];
    c.div_max = code_to_max(w[CODE_LSB +: CODE_W]);
    return c;
  endfunction

endpackage

// File: rtl/spi_presc_shadow.sv
module spi_presc_shadow
  import spi_presc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CSR_W-1:0] wdata,
  input  logic             load,
  output clk_cfg_t         active_cfg
);

  clk_cfg_t pending_q;
  clk_cfg_t active_q;
  clk_cfg_t source;

  // a write in the load cycle goes straight through
  always_comb source = we ? decode_csr(wdata) : pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= decode_csr('0);
      active_q  <= decode_csr('0);
    end else begin
      if (we)   pending_q <= decode_csr(wdata);
      if (load) active_q  <= source;
    end
  end

  assign active_cfg = active_q;

endmodule

// File: rtl/spi_presc_stage.sv
module spi_presc_stage #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         adv,
  input  logic [W-1:0] max_val,
  output logic [W-1:0] cnt,
  output logic         at_max
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)   cnt_q <= '0;
    else if (adv)       cnt_q <= (cnt_q == max_val) ? '0 : cnt_q + W'(1);
  end

  assign cnt    = cnt_q;
  assign at_max = (cnt_q == max_val);

endmodule

// File: rtl/spi_presc_cascade.sv
module spi_presc_cascade
  import spi_presc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  clk_cfg_t         cfg,
  output logic [PRE_W-1:0] pre_cnt,
  output logic [DIV_W-1:0] div_cnt,
  output logic             wrap
);

  logic pre_top;
  logic div_top;

  spi_presc_stage #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clear(!run), .adv(run),
    .max_val(cfg.pre_max), .cnt(pre_cnt), .at_max(pre_top)
  );

  spi_presc_stage #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clear(!run), .adv(run && pre_top),
    .max_val(cfg.div_max), .cnt(div_cnt), .at_max(div_top)
  );

  assign wrap = run && pre_top && div_top;

endmodule

// File: rtl/spi_presc_edge.sv
module spi_presc_edge (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic wrap,
  output logic tick,
  output logic phase
);

  logic tick_q;
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      tick_q  <= wrap;
      phase_q <= run ? (phase_q ^ wrap) : 1'b0;
    end
  end

  assign tick  = tick_q;
  assign phase = phase_q;

endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
  import spi_presc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  input  logic             sck_run,
  output logic             edge_tick,
  output logic             sck_phase
);

  clk_cfg_t         active_cfg;
  logic             period_wrap;
  logic             cfg_load;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [PRE_W-1:0] act_pre_max;
  logic [DIV_W-1:0] act_div_max;

  assign cfg_load    = !sck_run || period_wrap;
  assign act_pre_max = active_cfg.pre_max;
  assign act_div_max = active_cfg.div_max;

  spi_presc_shadow u_shadow (
    .clk(clk), .rst(rst), .we(csr_we), .wdata(csr_wdata),
    .load(cfg_load), .active_cfg(active_cfg)
  );

  spi_presc_cascade u_cascade (
    .clk(clk), .rst(rst), .run(sck_run), .cfg(active_cfg),
    .pre_cnt(pre_cnt), .div_cnt(div_cnt), .wrap(period_wrap)
  );

  spi_presc_edge u_edge (
    .clk(clk), .rst(rst), .run(sck_run), .wrap(period_wrap),
    .tick(edge_tick), .phase(sck_phase)
  );

endmodule

// File: rtl/spi_sck_prescaler_chk.sv
module spi_sck_prescaler_chk
  import spi_presc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             sck_run,
  input logic             edge_tick,
  input logic             sck_phase,
  input logic             period_wrap,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [DIV_W-1:0] div_cnt,
  input logic [PRE_W-1:0] act_pre_max,
  input logic [DIV_W-1:0] act_div_max
);

  // R6
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !sck_run |=> (!edge_tick && !sck_phase));

  // R7
  idle_clears_counters_chk: assert property (@(posedge clk) disable iff (rst)
    !sck_run |=> (pre_cnt == '0 && div_cnt == '0));

  // R4
  unity_ratio_every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (sck_run && act_pre_max == '0 && act_div_max == '0) |=> edge_tick);

  // R8
  cfg_held_mid_period_chk: assert property (@(posedge clk) disable iff (rst)
    (sck_run && !period_wrap) |=> ($stable(act_pre_max) && $stable(act_div_max)));

  // R10
  phase_flips_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    edge_tick |-> (sck_phase != $past(sck_phase)));

  // R10
  phase_holds_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_tick |-> ($stable(sck_phase) || !sck_phase));

  // R7
  tick_follows_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    period_wrap |=> edge_tick);

endmodule

bind spi_sck_prescaler spi_sck_prescaler_chk u_chk (
  .clk(clk), .rst(rst), .sck_run(sck_run), .edge_tick(edge_tick),
  .sck_phase(sck_phase), .period_wrap(period_wrap), .pre_cnt(pre_cnt),
  .div_cnt(div_cnt), .act_pre_max(act_pre_max), .act_div_max(act_div_max)
);

// File: tb/test_spi_sck_prescaler.sv
module test_spi_sck_prescaler;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int TICK_CAP   = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [15:0] csr_wdata = '0;
  logic        sck_run = 1'b0;
  logic        edge_tick;
  logic        sck_phase;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_sck_prescaler i_spi_sck_prescaler (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .sck_run(sck_run), .edge_tick(edge_tick), .sck_phase(sck_phase)
  );

  // cycles per edge from the written word (R2, R3, R4, R5)
  function automatic int exp_ratio(input logic [15:0] w);
    int pre = int'(w[12:8]) + 1;
    int dv;
    if (w[2:0] == 3'd7)       dv = 1;
    else if (w[2:0] > 3'd4)   dv = 2;
    else begin
      dv = 1;
      for (int i = 0; i <= int'(w[2:0]); i++) dv = dv * 2;
    end
    return pre * dv;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // program while idle
  task automatic write_idle(input logic [15:0] w);
    csr_we = 1'b1; csr_wdata = w;
    @(negedge clk);
    csr_we = 1'b0;
    @(negedge clk);
  endtask

  // count cycles to next tick; optionally strobe a write at a given count
  task automatic next_tick(input int write_at, input logic [15:0] wval, output int n);
    n = 0;
    do begin
      csr_we    = (n == write_at);
      csr_wdata = wval;
      @(negedge clk);
      n++;
    end while (!edge_tick && n < TICK_CAP);
    csr_we = 1'b0;
  endtask

  // start from idle and check first tick plus intervals, and the phase
  task automatic run_cfg(input logic [15:0] w, input int intervals, input string req);
    int n;
    int exp = exp_ratio(w);
    sck_run = 1'b0;
    @(negedge clk);
    write_idle(w);
    sck_run = 1'b1;
    next_tick(-1, '0, n);
    check({req, " first tick (R7)"}, n, exp);
    check("R10 phase after first tick", int'(sck_phase), 1);
    for (int k = 0; k < intervals; k++) begin
      next_tick(-1, '0, n);
      check({req, " interval"}, n, exp);
      check("R10 phase parity", int'(sck_phase), (k % 2 == 0) ? 0 : 1);
    end
    sck_run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tick at reset", int'(edge_tick), 0);
    check("R1 phase at reset", int'(sck_phase), 0);
    rst = 1'b0;
    sck_run = 1'b1;
    next_tick(-1, '0, n);
    check("R1 default ratio", n, 2);
    sck_run = 1'b0;
    @(negedge clk);

    // R3 every power-of-two code, prescale 3
    for (int c = 0; c < 5; c++) run_cfg(16'h0200 | 16'(c), 2, "R3");
    // R5 reserved codes
    run_cfg(16'h0105, 2, "R5 code5");
    run_cfg(16'h0106, 2, "R5 code6");
    // R4 unity ratio and code 7 with prescale
    run_cfg(16'h0007, 4, "R4 unity");
    run_cfg(16'h0407, 2, "R4 code7 pre5");
    // R2 ignored bits set; prescale extremes
    run_cfg(16'hE0F9 & 16'hE3F9, 2, "R2 ignored bits");
    run_cfg(16'h1F04, 1, "R2 ratio 1024");
    run_cfg(16'h1F07, 2, "R2 prescale 32");

    // R6 idle produces nothing
    write_idle(16'h0007);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        seen += int'(edge_tick) + int'(sck_phase);
      end
      check("R6 idle activity", seen, 0);
    end

    // R7 restart mid-period gives a full period
    write_idle(16'h0002);
    sck_run = 1'b1;
    repeat (5) @(negedge clk);
    sck_run = 1'b0;
    @(negedge clk);
    check("R6 phase cleared", int'(sck_phase), 0);
    sck_run = 1'b1;
    next_tick(-1, '0, n);
    check("R7 restart full period", n, 8);

    // R8 mid-period write (ratio 8 -> 4)
    next_tick(0, 16'h0001, n);
    check("R8 current period kept", n, 8);
    next_tick(-1, '0, n);
    check("R8 new period", n, 4);
    // R9 write in the wrap cycle (ratio 4 -> 12)
    next_tick(3, 16'h0201, n);
    check("R9 period with write at wrap", n, 4);
    next_tick(-1, '0, n);
    check("R9 next period uses new", n, 12);

    // R11 reset mid-run
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 tick cleared", int'(edge_tick), 0);
    check("R11 phase cleared", int'(sck_phase), 0);
    rst = 1'b0;
    sck_run = 1'b0;
    @(negedge clk);
    sck_run = 1'b1;
    next_tick(-1, '0, n);
    check("R11 default ratio restored", n, 2);
    sck_run = 1'b0;
    @(negedge clk);

    // random settings, prescale mostly small
    for (int t = 0; t < 30; t++) begin
      logic [15:0] w = 16'($urandom);
      if (t % 6 != 0) w[12:8] = w[12:8] & 5'h07;
      run_cfg(w, 2, "R3 random");
    end

    done = 1'b1;
  end

  initial begin
    wait (done || cyc >= WATCHDOG);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule